// File: doc/BRIEF.md
# Multichannel TDM Serial Port Engine

This block is the slave side of a time-division-multiplexed audio link. An external converter owns the link: it drives the bit clock and a one-bit-clock frame sync pulse. The port oversamples both in its own system clock domain. It then follows the frame as a programmable number of fixed-length slots. In each slot it shifts a word out on its transmit line and captures a word from its receive line.

A per-slot transmit mask selects the slots the port drives. In all other slots the output-enable is low, so a pad buffer leaves the line high-impedance and other devices can share it. A per-slot receive mask selects the slots whose words are stored. The system side hands over one word per slot as a flat slot-indexed bus, which is latched at frame start. Received words go into a slot-indexed store that is read through a registered port. A per-word valid pulse and per-frame start and done strobes give the timing. A typical stereo setup sends three left channels, one unused slot, three right channels and one unused slot, and receives the left input in slot 0 and the right input in slot 4.

Top module: `tdm_port`

## Requirements
- R1: During and right after reset, `tx_oe`, `rx_valid`, `frame_start`, `frame_done` and `framing_err` are all low.
- R2: A frame holds `slot_count_m1`+1 slots of `WORD_BITS` bits each (a field value of 7 selects 8 slots). The first bit of slot 0 is the bit clock period that follows the rising bit clock edge on which `fsync` is sampled high.
- R3: Words are shifted most significant bit first. `tx_sd` changes after a falling bit clock edge, and `rx_sd` is sampled on the rising edge.
- R4: `tx_oe` is high for a whole slot when that slot's transmit mask bit (bit i for slot i) is set and the slot lies inside the programmed count. It is low in every other slot and between frames.
- R5: The transmit words and the transmit mask are latched at frame start. Changes to `tx_words` or `tx_mask` during a frame do not alter what is sent in that frame.
- R6: After the last bit of slot i, if receive mask bit i is set (mask latched at frame start), the word is written to the store and `rx_valid` pulses for one cycle with `rx_slot`=i. Slots whose mask bit is clear, including those above the count, produce no pulse and keep their previously stored word.
- R7: `rx_rd_data` presents the stored word of slot `rx_rd_slot` one clock after it is applied.
- R8: `frame_done` pulses once per frame for one cycle. It pulses together with the valid pulse of the highest enabled receive slot, or at the end of the last slot if no slot in range is enabled.
- R9: A frame sync sampled high before the last bit of the last slot restarts the frame at slot 0 bit 0 and sets `framing_err`, which stays high until reset.
- R10: While `enable` is low, `tx_oe` is low from the next clock on, frame syncs are ignored, and nothing is captured or stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Port enable |
| slot_count_m1 | input | 3 | Number of slots per frame minus one |
| tx_mask | input | 8 | Per-slot transmit enable |
| rx_mask | input | 8 | Per-slot receive enable |
| bclk | input | 1 | Bit clock from the converter |
| fsync | input | 1 | Frame sync from the converter |
| rx_sd | input | 1 | Serial receive data |
| tx_sd | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Output enable for the transmit pad buffer |
| tx_words | input | 256 | Transmit words, slot i at bits [32i+31:32i] |
| frame_start | output | 1 | Pulse when a frame starts and transmit words are latched |
| rx_valid | output | 1 | Pulse when a received word is stored |
| rx_slot | output | 3 | Slot of the word shown with `rx_valid` |
| rx_word | output | 32 | Word shown with `rx_valid` |
| rx_rd_slot | input | 3 | Read address of the received-word store |
| rx_rd_data | output | 32 | Registered read data of the store |
| frame_done | output | 1 | Pulse when the frame's last enabled receive word is stored |
| framing_err | output | 1 | Sticky early-frame-sync flag |

## Verification
The design and its assertions assume a few things about the converter. Each level of the bit clock lasts for more than the synchronizer depth plus one system clock. Frame sync is high for exactly one bit clock period. `rx_sd` and `fsync` change only with the falling bit clock edge. The bench holds each bit clock level for six system clocks. It changes `fsync` and `rx_sd` only at the start of a low phase and raises `fsync` for a single bit period. Between frames it always leaves at least three idle bit periods, except in the deliberate early-sync case, where the second sync cuts into slot 1.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int unsigned TDM_SLOTS_DEF = 8;
  localparam int unsigned TDM_WORD_DEF  = 32;
  localparam int unsigned TDM_SYNC_DEF  = 2;

  typedef enum logic [1:0] {
    BCK_NONE = 2'd0,
    BCK_RISE = 2'd1,
    BCK_FALL = 2'd2
  } bck_evt_e;
endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync
  import tdm_pkg::*;
#(
  parameter int unsigned STAGES = TDM_SYNC_DEF
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     bclk,
  input  logic     fsync,
  input  logic     rx_sd,
  output bck_evt_e evt,
  output logic     fs_s,
  output logic     rx_s
);
  localparam int unsigned NDATA = 2;

  logic [STAGES:0] bck_sh;
  logic [NDATA-1:0] data_in;
  logic [NDATA-1:0] data_out;

  assign data_in = {rx_sd, fsync};

  always_ff @(posedge clk) begin
    if (rst) bck_sh <= '0;
    else     bck_sh <= {bck_sh[STAGES-1:0], bclk};
  end

  // data chains are one stage shorter so they line up with the newest bclk stage
  for (genvar g = 0; g < NDATA; g++) begin : g_chain
    logic [STAGES-1:0] sh;
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], data_in[g]};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= data_in[g];
      end
    end
    assign data_out[g] = sh[STAGES-1];
  end

  assign fs_s = data_out[0];
  assign rx_s = data_out[1];

  always_comb begin
    evt = BCK_NONE;
    if (bck_sh[STAGES-1] && !bck_sh[STAGES])      evt = BCK_RISE;
    else if (!bck_sh[STAGES-1] && bck_sh[STAGES]) evt = BCK_FALL;
  end
endmodule

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
  import tdm_pkg::*;
#(
  parameter int unsigned SLOTS     = TDM_SLOTS_DEF,
  parameter int unsigned WORD_BITS = TDM_WORD_DEF
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         enable,
  input  logic                         rise,
  input  logic                         fs_s,
  input  logic [$clog2(SLOTS)-1:0]     slot_count_m1,
  input  logic [SLOTS-1:0]             rx_mask,
  output logic                         active,
  output logic [$clog2(SLOTS)-1:0]     slot,
  output logic [$clog2(WORD_BITS)-1:0] bit_idx,
  output logic                         capture,
  output logic                         word_last,
  output logic [SLOTS-1:0]             rx_mask_q,
  output logic                         frame_start,
  output logic                         frame_done,
  output logic                         framing_err
);
  localparam int unsigned SW = $clog2(SLOTS);
  localparam int unsigned BW = $clog2(WORD_BITS);

  logic [SW-1:0] cnt_q;
  logic [SW-1:0] last_rx;
  logic          at_end;

  assign capture   = rise && active && enable;
  assign word_last = (bit_idx == BW'(WORD_BITS - 1));
  assign at_end    = word_last && (slot == cnt_q);

  // highest receive-enabled slot inside the count, else the final slot
  always_comb begin
    last_rx = cnt_q;
    for (int i = 0; i < int'(SLOTS); i++) begin
      if (rx_mask_q[i] && (i <= int'(cnt_q))) last_rx = SW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b0;
      slot        <= '0;
      bit_idx     <= '0;
      cnt_q       <= '0;
      rx_mask_q   <= '0;
      frame_start <= 1'b0;
      frame_done  <= 1'b0;
      framing_err <= 1'b0;
    end else begin
      frame_start <= 1'b0;
      frame_done  <= 1'b0;
      if (!enable) begin
        active <= 1'b0;
      end else if (rise) begin
        if (capture && word_last && (slot == last_rx)) frame_done <= 1'b1;
        if (fs_s) begin
          if (active && !at_end) framing_err <= 1'b1;
          active      <= 1'b1;
          slot        <= '0;
          bit_idx     <= '0;
          cnt_q       <= slot_count_m1;
          rx_mask_q   <= rx_mask;
          frame_start <= 1'b1;
        end else if (active) begin
          if (word_last) begin
            bit_idx <= '0;
            if (slot == cnt_q) active <= 1'b0;
            else               slot   <= slot + 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser
  import tdm_pkg::*;
#(
  parameter int unsigned SLOTS     = TDM_SLOTS_DEF,
  parameter int unsigned WORD_BITS = TDM_WORD_DEF
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         enable,
  input  logic                         fall,
  input  logic                         frame_start,
  input  logic                         active,
  input  logic [$clog2(SLOTS)-1:0]     slot,
  input  logic [$clog2(WORD_BITS)-1:0] bit_idx,
  input  logic [SLOTS*WORD_BITS-1:0]   tx_words,
  input  logic [SLOTS-1:0]             tx_mask,
  output logic                         tx_sd,
  output logic                         tx_oe
);
  localparam int unsigned BW = $clog2(WORD_BITS);

  logic [WORD_BITS-1:0] word_q [SLOTS];
  logic [SLOTS-1:0]     mask_q;
  logic [BW-1:0]        msb_idx;

  assign msb_idx = BW'(WORD_BITS - 1) - bit_idx;

  for (genvar g = 0; g < SLOTS; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst)              word_q[g] <= '0;
      else if (frame_start) word_q[g] <= tx_words[g*WORD_BITS +: WORD_BITS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              mask_q <= '0;
    else if (frame_start) mask_q <= tx_mask;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      tx_oe <= 1'b0;
      tx_sd <= 1'b0;
    end else if (fall) begin
      if (active) begin
        tx_oe <= mask_q[slot];
        tx_sd <= mask_q[slot] & word_q[slot][msb_idx];
      end else begin
        tx_oe <= 1'b0;
        tx_sd <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
  import tdm_pkg::*;
#(
  parameter int unsigned SLOTS     = TDM_SLOTS_DEF,
  parameter int unsigned WORD_BITS = TDM_WORD_DEF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     capture,
  input  logic                     word_last,
  input  logic                     rx_s,
  input  logic [$clog2(SLOTS)-1:0] slot,
  input  logic [SLOTS-1:0]         rx_mask_q,
  input  logic [$clog2(SLOTS)-1:0] rd_slot,
  output logic                     rx_valid,
  output logic [$clog2(SLOTS)-1:0] rx_slot,
  output logic [WORD_BITS-1:0]     rx_word,
  output logic [WORD_BITS-1:0]     rd_data
);
  logic [WORD_BITS-1:0] shreg;
  logic [WORD_BITS-1:0] next_word;
  logic                 store;
  logic [WORD_BITS-1:0] mem [SLOTS];

  assign next_word = {shreg[WORD_BITS-2:0], rx_s};
  assign store     = capture && word_last && rx_mask_q[slot];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      rx_valid <= 1'b0;
      rx_slot  <= '0;
      rx_word  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (capture) shreg <= next_word;
      if (store) begin
        rx_valid <= 1'b1;
        rx_slot  <= slot;
        rx_word  <= next_word;
      end
    end
  end

  // plain write and registered read so a block RAM can hold the store
  always_ff @(posedge clk) begin
    if (store) mem[slot] <= next_word;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_slot];
  end
endmodule

// File: rtl/tdm_port.sv
module tdm_port
  import tdm_pkg::*;
#(
  parameter int unsigned SLOTS       = TDM_SLOTS_DEF,
  parameter int unsigned WORD_BITS   = TDM_WORD_DEF,
  parameter int unsigned SYNC_STAGES = TDM_SYNC_DEF
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           enable,
  input  logic [$clog2(SLOTS)-1:0]       slot_count_m1,
  input  logic [SLOTS-1:0]               tx_mask,
  input  logic [SLOTS-1:0]               rx_mask,
  input  logic                           bclk,
  input  logic                           fsync,
  input  logic                           rx_sd,
  output logic                           tx_sd,
  output logic                           tx_oe,
  input  logic [SLOTS*WORD_BITS-1:0]     tx_words,
  output logic                           frame_start,
  output logic                           rx_valid,
  output logic [$clog2(SLOTS)-1:0]       rx_slot,
  output logic [WORD_BITS-1:0]           rx_word,
  input  logic [$clog2(SLOTS)-1:0]       rx_rd_slot,
  output logic [WORD_BITS-1:0]           rx_rd_data,
  output logic                           frame_done,
  output logic                           framing_err
);
  localparam int unsigned SW = $clog2(SLOTS);
  localparam int unsigned BW = $clog2(WORD_BITS);

  bck_evt_e      evt;
  logic          fs_s, rx_s, rise, fall;
  logic          active, capture, word_last;
  logic [SW-1:0] slot;
  logic [BW-1:0] bit_idx;
  logic [SLOTS-1:0] rx_mask_q;

  assign rise = (evt == BCK_RISE);
  assign fall = (evt == BCK_FALL);

  tdm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync), .rx_sd(rx_sd),
    .evt(evt), .fs_s(fs_s), .rx_s(rx_s)
  );

  tdm_frame_ctrl #(.SLOTS(SLOTS), .WORD_BITS(WORD_BITS)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .rise(rise), .fs_s(fs_s),
    .slot_count_m1(slot_count_m1), .rx_mask(rx_mask),
    .active(active), .slot(slot), .bit_idx(bit_idx), .capture(capture),
    .word_last(word_last), .rx_mask_q(rx_mask_q), .frame_start(frame_start),
    .frame_done(frame_done), .framing_err(framing_err)
  );

  tdm_tx_ser #(.SLOTS(SLOTS), .WORD_BITS(WORD_BITS)) u_tx (
    .clk(clk), .rst(rst), .enable(enable), .fall(fall),
    .frame_start(frame_start), .active(active), .slot(slot),
    .bit_idx(bit_idx), .tx_words(tx_words), .tx_mask(tx_mask),
    .tx_sd(tx_sd), .tx_oe(tx_oe)
  );

  tdm_rx_deser #(.SLOTS(SLOTS), .WORD_BITS(WORD_BITS)) u_rx (
    .clk(clk), .rst(rst), .capture(capture), .word_last(word_last),
    .rx_s(rx_s), .slot(slot), .rx_mask_q(rx_mask_q), .rd_slot(rx_rd_slot),
    .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_word(rx_word),
    .rd_data(rx_rd_data)
  );
endmodule

// File: rtl/tdm_port_chk.sv
module tdm_port_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic tx_oe,
  input logic rx_valid,
  input logic frame_start,
  input logic frame_done,
  input logic framing_err
);
  // R10
  oe_off_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !tx_oe);

  // R10
  start_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> $past(enable));

  // R6
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R9
  framing_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    framing_err |=> framing_err);

  // R2
  start_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);
endmodule

bind tdm_port tdm_port_chk i_chk (
  .clk(clk), .rst(rst), .enable(enable), .tx_oe(tx_oe),
  .rx_valid(rx_valid), .frame_start(frame_start),
  .frame_done(frame_done), .framing_err(framing_err)
);

// File: tb/test_tdm_port.sv
module test_tdm_port;
  localparam int HALF = 6;
  // {count_m1[34:32], tx_mask[31:24], rx_mask[23:16], seed[15:0]}
  localparam logic [34:0] VEC [6] = '{
    {3'd7, 8'hFF, 8'hFF, 16'd1},
    {3'd7, 8'h77, 8'h11, 16'd2},
    {3'd3, 8'h0F, 8'h05, 16'd3},
    {3'd1, 8'hF2, 8'hF0, 16'd4},
    {3'd7, 8'h00, 8'h80, 16'd5},
    {3'd0, 8'hFF, 8'h01, 16'd6}
  };

  logic clk = 1'b0, rst = 1'b1, enable = 1'b0;
  logic [2:0] slot_count_m1 = '0;
  logic [7:0] tx_mask = '0, rx_mask = '0;
  logic bclk = 1'b0, fsync = 1'b0, rx_sd = 1'b0;
  logic [255:0] tx_words = '0;
  logic [2:0] rx_rd_slot = '0;
  logic tx_sd, tx_oe, frame_start, rx_valid, frame_done, framing_err;
  logic [2:0] rx_slot;
  logic [31:0] rx_word, rx_rd_data;

  int n_chk = 0, n_fail = 0;
  int vcnt [8];
  int dcnt = 0;
  logic [31:0] model [8];
  bit known [8];
  bit finished = 0;

  always #4 clk = ~clk;

  tdm_port i_tdm_port (
    .clk(clk), .rst(rst), .enable(enable), .slot_count_m1(slot_count_m1),
    .tx_mask(tx_mask), .rx_mask(rx_mask), .bclk(bclk), .fsync(fsync),
    .rx_sd(rx_sd), .tx_sd(tx_sd), .tx_oe(tx_oe), .tx_words(tx_words),
    .frame_start(frame_start), .rx_valid(rx_valid), .rx_slot(rx_slot),
    .rx_word(rx_word), .rx_rd_slot(rx_rd_slot), .rx_rd_data(rx_rd_data),
    .frame_done(frame_done), .framing_err(framing_err)
  );

  initial for (int i = 0; i < 8; i++) begin vcnt[i] = 0; known[i] = 0; model[i] = '0; end

  always @(posedge clk) begin
    if (!rst) begin
      if (rx_valid) vcnt[rx_slot] = vcnt[rx_slot] + 1;
      if (frame_done) dcnt = dcnt + 1;
    end
  end

  function automatic logic [31:0] txw(int seed, int s);
    return 32'hB38F_0000 ^ (32'(seed) * 32'h9E37_79B1) ^ (32'(s) * 32'h0101_0111);
  endfunction

  function automatic logic [31:0] rxw(int seed, int s);
    logic [31:0] t = txw(seed, s);
    return {t[15:0], ~t[31:16]} ^ 32'h5A5A_C3C3;
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bit_period(input logic f, input logic d, output logic oe, output logic q);
    bclk = 1'b0; fsync = f; rx_sd = d;
    repeat (HALF) @(negedge clk);
    oe = tx_oe; q = tx_sd;
    bclk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic read_slot(input int s, output logic [31:0] d);
    rx_rd_slot = 3'(s);
    @(negedge clk);
    d = rx_rd_data;
  endtask

  task automatic check_store(input string req);
    logic [31:0] d;
    for (int s = 0; s < 8; s++) begin
      if (known[s]) begin
        read_slot(s, d);
        chk(d == model[s], req, $sformatf("store slot %0d", s), d, model[s]);
      end
    end
  endtask

  task automatic run_frame(input logic [34:0] v, input int abort_bits);
    int n, seed, k;
    logic [7:0] txm, rxm;
    int sv [8];
    int sd;
    bit cut;
    logic oe, q, oa, oo;
    logic [31:0] got, rw;
    n = int'(v[34:32]) + 1; txm = v[31:24]; rxm = v[23:16]; seed = int'(v[15:0]);
    slot_count_m1 = v[34:32]; tx_mask = txm; rx_mask = rxm;
    for (int s = 0; s < 8; s++) tx_words[s*32 +: 32] = txw(seed, s);
    for (int s = 0; s < 8; s++) sv[s] = vcnt[s];
    sd = dcnt; k = 0; cut = 0;
    bit_period(1'b1, 1'b0, oe, q);
    for (int s = 0; s < n && !cut; s++) begin
      rw = rxw(seed, s); got = '0; oa = 1'b1; oo = 1'b0;
      for (int b = 0; b < 32; b++) begin
        if (abort_bits >= 0 && k >= abort_bits) begin cut = 1; break; end
        bit_period(1'b0, rw[31-b], oe, q);
        got = {got[30:0], q}; oa &= oe; oo |= oe; k++;
        if (s == 0 && b == 0) begin tx_words = ~tx_words; tx_mask = ~txm; end
      end
      if (!cut) begin
        chk(oa == txm[s] && oo == txm[s], "R4", $sformatf("oe slot %0d", s), {31'd0, oo}, {31'd0, txm[s]});
        if (txm[s]) chk(got == txw(seed, s), "R2 R3 R5", $sformatf("tx word slot %0d", s), got, txw(seed, s));
      end
    end
    if (cut) begin
      for (int s = 0; s < abort_bits / 32 && s < n; s++)
        if (rxm[s]) begin model[s] = rxw(seed, s); known[s] = 1; end
      return;
    end
    for (int i = 0; i < 3; i++) bit_period(1'b0, 1'b0, oe, q);
    for (int s = 0; s < 8; s++) begin
      int e;
      e = (s < n && rxm[s]) ? 1 : 0;
      chk(vcnt[s] - sv[s] == e, "R6", $sformatf("valid count slot %0d", s), 32'(vcnt[s] - sv[s]), 32'(e));
      if (e == 1) begin model[s] = rxw(seed, s); known[s] = 1; end
    end
    chk(dcnt - sd == 1, "R8", "frame_done count", 32'(dcnt - sd), 32'd1);
    check_store("R6 R7");
  endtask

  initial begin
    logic oe, q, oo;
    int sv [8];
    int sd, vsum;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(tx_oe == 0 && rx_valid == 0 && frame_done == 0 && framing_err == 0 && frame_start == 0,
        "R1", "outputs in reset", {27'd0, tx_oe, rx_valid, frame_done, framing_err, frame_start}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_oe == 0 && framing_err == 0, "R1", "outputs after reset", {30'd0, tx_oe, framing_err}, 32'd0);
    enable = 1'b1;
    for (int i = 0; i < 6; i++) run_frame(VEC[i], -1);
    chk(framing_err == 0, "R9", "no error on clean frames", {31'd0, framing_err}, 32'd0);

    // R10 disabled: syncs ignored, nothing driven or stored
    enable = 1'b0; tx_mask = 8'hFF; rx_mask = 8'hFF; slot_count_m1 = 3'd7;
    for (int s = 0; s < 8; s++) sv[s] = vcnt[s];
    sd = dcnt; oo = 1'b0;
    bit_period(1'b1, 1'b1, oe, q); oo |= oe;
    for (int b = 0; b < 70; b++) begin bit_period(1'b0, 1'(b % 3), oe, q); oo |= oe; end
    vsum = 0;
    for (int s = 0; s < 8; s++) vsum += vcnt[s] - sv[s];
    chk(oo == 0, "R10", "tx_oe while disabled", {31'd0, oo}, 32'd0);
    chk(vsum == 0 && dcnt == sd, "R10", "no capture while disabled", 32'(vsum + dcnt - sd), 32'd0);
    check_store("R10");
    enable = 1'b1;
    run_frame(VEC[1], -1);

    // R9 early frame sync cuts into slot 1, frame restarts at slot 0
    run_frame(VEC[0], 40);
    chk(framing_err == 0, "R9", "no error before early sync", {31'd0, framing_err}, 32'd0);
    run_frame(VEC[2], -1);
    chk(framing_err == 1, "R9", "error after early sync", {31'd0, framing_err}, 32'd1);
    run_frame(VEC[5], -1);
    chk(framing_err == 1, "R9", "error stays set", {31'd0, framing_err}, 32'd1);

    // R1 R9 reset clears the error
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(framing_err == 0 && tx_oe == 0, "R1 R9", "reset clears error", {30'd0, framing_err, tx_oe}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule